// File: doc/BRIEF.md
# Talker-Side Three-Wire Handshake Controller

This block is the sending side of an interlocked three-wire handshake on a shared parallel bus with several listeners. Bytes arrive on a valid/ready stream. The controller takes one byte at a time and places it on an 8-bit data bus. It waits a programmable number of settle cycles. It then waits until every listener reports ready, and only then asserts the active-low data-valid strobe. It holds the strobe and the byte until every listener reports the byte taken, and then releases the strobe. The next byte may be loaded as soon as the strobe is released, while the listeners are still resetting their own lines.

The two listener lines are wired-OR and active low. The controller takes them as raw wire levels. A ready line at level 1 means that no listener still claims to be not ready. A taken line at level 1 means that every listener has accepted the byte. Both lines pass through synchronisers before the control logic uses them.

When a byte is offered while both lines read high, the lines are in a state that cannot occur in a correct handshake. The controller refuses the byte and raises a sticky error flag. It waits in a fault state until an explicit clear input is seen.

Top module: `talker_hs_ctrl`

## Requirements
- R1: While reset is held, and once it is released, `src_valid_n` is 1, `err_flag` is 0 and `bus_data` is 0.
- R2: In the idle state, with the two synchronised lines not both high, `in_ready` is 1. A byte offered with `in_valid` appears on `bus_data` one edge later, while `src_valid_n` is still 1. In every other state `in_ready` is 0.
- R3: When `acc_ready_ln` is already high, `src_valid_n` falls exactly SETTLE_CYC+2 rising edges after the edge that loads `bus_data`.
- R4: `src_valid_n` falls only after `acc_ready_ln` (level 1 = all ready) is seen high. A rise of that line at negedge r, counted from the negedge after the load edge, makes the strobe fall at edge max(SETTLE_CYC+2, r+3). The r+3 term is two synchroniser stages plus one register.
- R5: Once low, `src_valid_n` stays low until `acc_taken_ln` (level 1 = all taken) is seen high. It returns to 1 exactly three edges after that line rises, whatever `acc_ready_ln` does.
- R6: `bus_data` changes only on the edge that accepts a byte. It holds through the settle delay and while `src_valid_n` is low.
- R7: If `in_valid` is 1 in the idle state while both synchronised lines are high, `in_ready` is 0 and the byte is not taken. On the next edge `err_flag` becomes 1 and `src_valid_n` stays 1. No error is raised while nothing is offered.
- R8: While `err_flag` is 1 it stays 1, and no byte is accepted, until `err_clear` is sampled high. `err_flag` is 0 one edge later.
- R9: If a fresh illegal-line detection falls in the same cycle as a held `err_clear`, the detection wins and `err_flag` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_data | input | 8 | Byte offered on the input stream |
| in_valid | input | 1 | Input stream valid |
| in_ready | output | 1 | Input stream ready; a byte moves when both are high |
| err_clear | input | 1 | Clears the sticky error flag |
| bus_data | output | 8 | Data lines driven to the bus |
| src_valid_n | output | 1 | Active-low data-valid strobe |
| acc_ready_ln | input | 1 | Wired-OR not-ready line level; 1 means all listeners ready |
| acc_taken_ln | input | 1 | Wired-OR not-taken line level; 1 means all listeners took the byte |
| err_flag | output | 1 | Sticky flag for the illegal both-high line state |

## Verification
Clearing the sticky error and detecting the illegal line state can fall in the same cycle. This happens when `err_clear` is held across the edge that returns the controller to idle, while a byte is still offered and both listener lines are still high. The bench provokes exactly this case. It expects the flag to drop for one cycle and then rise again on the following edge, with `in_ready` low and the data lines unchanged throughout. The handshake sweep separately sets the ready-line lag against the settle delay, and the expected strobe edge is computed as the later of the two.

// File: rtl/ths_pkg.sv
package ths_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_SETTLE    = 3'd1,
    ST_WAIT_RDY  = 3'd2,
    ST_WAIT_TAKE = 3'd3,
    ST_FAULT     = 3'd4
  } ths_state_e;
endpackage

// File: rtl/ths_rst_sync.sv
module ths_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q <= '0;
    end else begin
      sh_q[0] <= 1'b1;
      for (int s = 1; s < STAGES; s++) sh_q[s] <= sh_q[s-1];
    end
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/ths_sync.sv
module ths_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ths_settle_timer.sv
module ths_settle_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 2);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load)              cnt_d = CW'(CYCLES);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0) && !load;

  // R3: once counting has begun, the done indication stays low for the following cycle
  p_no_early_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (CYCLES > 0)) |=> !done);
endmodule

// File: rtl/ths_fsm.sv
module ths_fsm
  import ths_pkg::*;
#(
  parameter int DW         = 8,
  parameter int SETTLE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          err_clear,
  input  logic          rdy_s,
  input  logic          take_s,
  input  logic          tmr_done,
  output logic          tmr_load,
  output logic [DW-1:0] data_q,
  output logic          dav_n_q,
  output logic          err_q
);
  localparam int SW      = $clog2(SETTLE_CYC + 3);
  localparam int SAT_MAX = SETTLE_CYC + 2;

  ths_state_e state_q, state_d;
  logic       dav_n_d, err_d;
  logic       illegal, accept;

  assign illegal  = rdy_s && take_s;
  assign in_ready = (state_q == ST_IDLE) && !illegal;
  assign accept   = in_valid && in_ready;
  assign tmr_load = accept;

  always_comb begin
    state_d = state_q;
    dav_n_d = dav_n_q;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid && illegal) begin
          err_d   = 1'b1;
          state_d = ST_FAULT;
        end else if (accept) begin
          state_d = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (tmr_done) state_d = ST_WAIT_RDY;
      end
      ST_WAIT_RDY: begin
        if (rdy_s) begin
          dav_n_d = 1'b0;
          state_d = ST_WAIT_TAKE;
        end
      end
      ST_WAIT_TAKE: begin
        if (take_s) begin
          dav_n_d = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_FAULT: begin
        if (err_clear) begin
          err_d   = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: begin
        dav_n_d = 1'b1;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dav_n_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dav_n_q <= dav_n_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (accept) data_q <= in_data;
  end

  // Cycle count since the last byte load, saturating; used by the settle check.
  logic [SW-1:0] since_load_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            since_load_q <= '0;
    else if (accept)                       since_load_q <= '0;
    else if (since_load_q != SW'(SAT_MAX)) since_load_q <= since_load_q + 1'b1;
  end

  p_settle_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dav_n_q) |-> (since_load_q >= SW'(SAT_MAX)));

  p_fall_needs_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dav_n_q) |-> $past(rdy_s));

  p_rise_needs_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dav_n_q) |-> $past(take_s));

  p_data_moves_on_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> $past(in_valid && in_ready));

  p_detect_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && in_valid && rdy_s && take_s) |=> (err_q && dav_n_q));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clear) |=> err_q);

  p_fault_blocks_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !in_ready);
endmodule

// File: rtl/talker_hs_ctrl.sv
module talker_hs_ctrl #(
  parameter int DW          = 8,
  parameter int SETTLE_CYC  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          err_clear,
  output logic [DW-1:0] bus_data,
  output logic          src_valid_n,
  input  logic          acc_ready_ln,
  input  logic          acc_taken_ln,
  output logic          err_flag
);
  localparam int RST_STAGES = 2;

  logic       srst_n;
  logic [1:0] lines_s;
  logic       tmr_load, tmr_done;

  ths_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ths_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .d     ({acc_taken_ln, acc_ready_ln}),
    .q     (lines_s)
  );

  ths_settle_timer #(.CYCLES(SETTLE_CYC)) u_tmr (
    .clk   (clk),
    .rst_n (srst_n),
    .load  (tmr_load),
    .done  (tmr_done)
  );

  ths_fsm #(.DW(DW), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (srst_n),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .err_clear (err_clear),
    .rdy_s     (lines_s[0]),
    .take_s    (lines_s[1]),
    .tmr_done  (tmr_done),
    .tmr_load  (tmr_load),
    .data_q    (bus_data),
    .dav_n_q   (src_valid_n),
    .err_q     (err_flag)
  );

  // R1: the strobe is never low while the flag is set
  p_strobe_idle_in_fault_r1: assert property (@(posedge clk) disable iff (!srst_n)
    err_flag |-> src_valid_n);
endmodule

// File: tb/talker_hs_ctrl_bench.sv
module talker_hs_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 4;
  localparam int WD_LIMIT   = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] in_data;
  logic       in_valid;
  logic       in_ready;
  logic       err_clear;
  logic [7:0] bus_data;
  logic       src_valid_n;
  logic       acc_ready_ln;
  logic       acc_taken_ln;
  logic       err_flag;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  talker_hs_ctrl #(.DW(8), .SETTLE_CYC(SETTLE), .SYNC_STAGES(2)) u_talker_hs_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_data      (in_data),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .err_clear    (err_clear),
    .bus_data     (bus_data),
    .src_valid_n  (src_valid_n),
    .acc_ready_ln (acc_ready_ln),
    .acc_taken_ln (acc_taken_ln),
    .err_flag     (err_flag)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog: cycles %0d expected below %0d", cyc, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // One full transfer; rl/al are listener lags in negedges.
  task automatic xfer(input logic [7:0] b, input int rl, input int al);
    int exp_fall;
    int exp_rise;
    in_data      = b;
    in_valid     = 1'b1;
    acc_ready_ln = 1'b0;
    acc_taken_ln = 1'b0;
    chk("R2 ready offered in idle", in_ready, 1);
    tick();
    in_valid = 1'b0;
    chk("R2 byte on bus after load", bus_data, b);
    chk("R2 strobe high at load", src_valid_n, 1);
    exp_fall = (SETTLE + 2 > rl + 3) ? SETTLE + 2 : rl + 3;
    for (int c = 0; c <= exp_fall; c++) begin
      if (c == rl) acc_ready_ln = 1'b1;
      if (c > 0) begin
        if (rl + 3 > SETTLE + 2) chk("R4 strobe vs ready lag", src_valid_n, (c >= exp_fall) ? 0 : 1);
        else                     chk("R3 strobe vs settle", src_valid_n, (c >= exp_fall) ? 0 : 1);
        chk("R6 data held", bus_data, b);
        chk("R2 not ready when busy", in_ready, 0);
      end
      if (c < exp_fall) tick();
    end
    acc_ready_ln = 1'b0;
    exp_rise = al + 3;
    for (int c = 0; c <= exp_rise; c++) begin
      if (c == al) acc_taken_ln = 1'b1;
      if (c > 0) begin
        chk("R5 strobe release", src_valid_n, (c >= exp_rise) ? 1 : 0);
        chk("R6 data held while strobe low", bus_data, b);
      end
      if (c < exp_rise) tick();
    end
  endtask

  initial begin
    logic [7:0] last;
    rst_n        = 1'b0;
    in_data      = 8'h00;
    in_valid     = 1'b0;
    err_clear    = 1'b0;
    acc_ready_ln = 1'b0;
    acc_taken_ln = 1'b0;
    repeat (3) tick();
    chk("R1 strobe in reset", src_valid_n, 1);
    chk("R1 flag in reset", err_flag, 0);
    chk("R1 data in reset", bus_data, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 strobe after release", src_valid_n, 1);
    chk("R1 flag after release", err_flag, 0);

    // Sweep listener lags against the settle delay.
    for (int rl = 0; rl <= SETTLE + 3; rl++) begin
      for (int al = 0; al <= 3; al++) begin
        xfer(8'((rl * 37 + al * 11 + 5) & 8'hFF), rl, al);
      end
    end
    last = bus_data;

    // R7: illegal state with nothing offered raises nothing.
    acc_ready_ln = 1'b1;
    acc_taken_ln = 1'b1;
    repeat (3) tick();
    chk("R7 no flag without offer", err_flag, 0);
    chk("R7 ready low on illegal lines", in_ready, 0);
    in_data  = 8'hA5;
    in_valid = 1'b1;
    chk("R7 offer refused", in_ready, 0);
    tick();
    chk("R7 flag set", err_flag, 1);
    chk("R7 strobe stays high", src_valid_n, 1);
    chk("R7 byte not taken", bus_data, last);
    acc_ready_ln = 1'b0;
    acc_taken_ln = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R8 flag sticky", err_flag, 1);
      chk("R8 no accept in fault", in_ready, 0);
      chk("R8 data unchanged in fault", bus_data, last);
    end
    in_valid  = 1'b0;
    err_clear = 1'b1;
    tick();
    err_clear = 1'b0;
    chk("R8 flag cleared", err_flag, 0);
    chk("R8 ready after clear", in_ready, 1);
    xfer(8'hA5, 1, 2);

    // R9: held clear meets a fresh detection.
    acc_ready_ln = 1'b1;
    acc_taken_ln = 1'b1;
    repeat (3) tick();
    in_data  = 8'h5A;
    in_valid = 1'b1;
    tick();
    chk("R9 first detection", err_flag, 1);
    err_clear = 1'b1;
    tick();
    chk("R9 flag drops on clear", err_flag, 0);
    chk("R9 still refusing", in_ready, 0);
    tick();
    chk("R9 detection beats clear", err_flag, 1);
    chk("R9 data unchanged", bus_data, 8'hA5);
    err_clear    = 1'b0;
    in_valid     = 1'b0;
    acc_ready_ln = 1'b0;
    acc_taken_ln = 1'b0;
    repeat (3) tick();
    chk("R8 flag sticky after lines drop", err_flag, 1);
    err_clear = 1'b1;
    tick();
    err_clear = 1'b0;
    chk("R8 flag cleared again", err_flag, 0);
    xfer(8'h3C, 0, 0);
    tick();
    chk("R1 strobe idle at end", src_valid_n, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule